// File: doc/BRIEF.md
# Serial Link Flow Controller

This block throttles a serial link in both directions. On the receive side it watches how full the local receive buffer is. When the fill level reaches an upper threshold it signals the far end to stop. When the level drops below a separate lower threshold it lets the far end resume. The block can signal this in one of two ways:

- **Wire mode:** a dedicated ready-to-receive output goes low to stop the far end and high to let it resume.
- **In-band mode:** the block queues a pause character (0x13) or a resume character (0x11) for the transmit serializer.

On the transmit side the block decides when a payload byte may be handed to the serializer. It holds payload while the remote clear-to-send input is low in wire mode. In in-band mode it holds payload from the cycle after a pause character is received until a resume character arrives.

Queued control characters take precedence over payload, but only when the serializer is idle, so a frame that has already started is never cut short. In in-band mode the two flow characters are removed from the received byte stream and never reach the data output. The serializers themselves are outside this block, and so is any escaping of payload bytes that happen to equal a flow character.

Top module: `uart_flow_ctrl`

## Requirements
- R1: After reset the block is in this state: the far end is not paused, `rts_out` is high, and no control character is pending.
- R2: In wire mode (`mode_sel`=0), `ser_load` and `pay_ready` are high only in a cycle where all three hold: `pay_valid` is high, `cts_in` is high and `ser_busy` is low. `ser_byte` then equals `pay_byte`.
- R3: While `ser_busy` is high, `ser_load` stays low. Dropping `cts_in` during a frame does not affect that frame; it only blocks the next one.
- R4: When `occupancy` >= `thresh_hi`, the receive side enters the stopped state at the next clock edge. In wire mode `rts_out` is then low.
- R5: The stopped state is left at the first clock edge where `occupancy` < `thresh_lo`. Between the two thresholds the state does not change.
- R6: In in-band mode (`mode_sel`=1), entering the stopped state queues the pause character 0x13 and leaving it queues the resume character 0x11. `rts_out` stays high in this mode.
- R7: In in-band mode, when the serializer is idle and a control character is pending, that character is loaded in place of any waiting payload byte. The pending slot clears at that edge.
- R8: A new stop or release event that arrives before the pending character has been loaded replaces that character.
- R9: In in-band mode, a received 0x13 blocks payload from the next cycle on, and a received 0x11 allows it again from the next cycle on. Control characters are still sent while payload is blocked.
- R10: In in-band mode, received bytes 0x11 and 0x13 give no `rx_out_valid`. Every other byte is forwarded in the same cycle, unchanged. In wire mode all bytes are forwarded and none of them changes the paused state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_sel | input | 1 | 0 = wire handshake, 1 = in-band characters; held stable outside reset |
| occupancy | input | OCC_W | Receive buffer fill level |
| thresh_hi | input | OCC_W | Fill level at which the far end is stopped |
| thresh_lo | input | OCC_W | Fill level below which the far end is released (must be <= thresh_hi) |
| rx_in_valid | input | 1 | A received byte is present |
| rx_in_byte | input | 8 | Received byte |
| rx_out_valid | output | 1 | Forwarded byte is present |
| rx_out_byte | output | 8 | Forwarded byte |
| pay_valid | input | 1 | Payload byte waiting to be sent |
| pay_byte | input | 8 | Payload byte |
| pay_ready | output | 1 | Payload byte taken this cycle |
| ser_busy | input | 1 | Transmit serializer is sending a frame |
| ser_load | output | 1 | Start a frame with `ser_byte` |
| ser_byte | output | 8 | Byte for the serializer |
| cts_in | input | 1 | Remote clear-to-send, active high |
| rts_out | output | 1 | Local ready-to-receive, active high |

## Verification
Two things often fall in the same idle-serializer cycle: a control character becomes pending because the fill level crossed a threshold, and a payload byte is waiting to be sent. Holding `pay_valid` high continuously while the serializer is busy creates this collision, and so does swinging `occupancy` across both thresholds within one frame. The reference model resolves each idle cycle on its own: control character first, and the newest event wins the slot. It then compares `ser_load`, `ser_byte` and `pay_ready` against the design on every clock. A second overlap is also provoked: a pause character arriving in the same cycle that a control character is due to go out. Here the control character must still be sent while payload stays blocked.

// File: rtl/fc_pkg.sv
// Shared constants and types for the serial link flow controller.
// Assumes 8-bit characters on both the receive and transmit sides.
package fc_pkg;
    localparam int FC_BYTE_W = 8;

    typedef enum logic {
        FC_MODE_WIRE   = 1'b0,
        FC_MODE_INBAND = 1'b1
    } fc_mode_e;

    localparam logic [FC_BYTE_W-1:0] FC_CHAR_PAUSE  = 8'h13;
    localparam logic [FC_BYTE_W-1:0] FC_CHAR_RESUME = 8'h11;
endpackage

// File: rtl/fc_level_track.sv
// Hysteresis tracker for receive-buffer fill level.
// Enters "stopped" at occ >= hi and leaves it at occ < lo. It also gives
// single-cycle rise/fall indications that are valid for the coming edge.
// Assumes lo <= hi.
module fc_level_track #(
    parameter int OCC_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OCC_W-1:0] occ,
    input  logic [OCC_W-1:0] hi,
    input  logic [OCC_W-1:0] lo,
    output logic             stopped,
    output logic             stop_rise,
    output logic             stop_fall
);
    logic stop_q;
    logic stop_nxt;

    // Next stop state: above-high enters, below-low leaves, otherwise hold.
    always_comb begin
        if (stop_q) stop_nxt = (occ >= lo);
        else        stop_nxt = (occ >= hi);
    end

    // Register the stop state.
    always_ff @(posedge clk) begin
        if (!rst_n) stop_q <= 1'b0;
        else        stop_q <= stop_nxt;
    end

    assign stopped   = stop_q;
    assign stop_rise = ~stop_q & stop_nxt;
    assign stop_fall = stop_q & ~stop_nxt;
endmodule

// File: rtl/fc_rx_filter.sv
// Receive-side character filter.
// In in-band mode it removes the pause/resume characters from the stream and
// keeps a "remote paused" flag. In wire mode it passes every byte through.
module fc_rx_filter
    import fc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 inband,
    input  logic                 in_valid,
    input  logic [FC_BYTE_W-1:0] in_byte,
    output logic                 out_valid,
    output logic [FC_BYTE_W-1:0] out_byte,
    output logic                 remote_paused
);
    logic is_pause;
    logic is_resume;
    logic paused_q;

    // Recognise flow characters only when in-band signalling is active.
    always_comb begin
        is_pause  = inband && in_valid && (in_byte == FC_CHAR_PAUSE);
        is_resume = inband && in_valid && (in_byte == FC_CHAR_RESUME);
    end

    // Track whether the far end has asked us to stop sending.
    always_ff @(posedge clk) begin
        if (!rst_n)         paused_q <= 1'b0;
        else if (is_pause)  paused_q <= 1'b1;
        else if (is_resume) paused_q <= 1'b0;
    end

    assign out_valid     = in_valid & ~(is_pause | is_resume);
    assign out_byte      = in_byte;
    assign remote_paused = paused_q;
endmodule

// File: rtl/fc_tx_arbiter.sv
// Transmit-side arbiter.
// Holds one pending control character and loads it ahead of payload when the
// serializer is idle. Payload is gated by clear-to-send (wire mode) or by
// the remote paused flag (in-band mode). Assumes the serializer raises busy
// from the cycle after a load until its frame ends.
module fc_tx_arbiter
    import fc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 inband,
    input  logic                 stop_rise,
    input  logic                 stop_fall,
    input  logic                 cts_in,
    input  logic                 remote_paused,
    input  logic                 ser_busy,
    input  logic                 pay_valid,
    input  logic [FC_BYTE_W-1:0] pay_byte,
    output logic                 pay_ready,
    output logic                 ser_load,
    output logic [FC_BYTE_W-1:0] ser_byte
);
    logic                 pend_v;
    logic [FC_BYTE_W-1:0] pend_c;
    logic                 send_ctrl;
    logic                 send_pay;
    logic                 pay_allowed;

    // Decide what, if anything, goes to the serializer this cycle.
    always_comb begin
        pay_allowed = inband ? ~remote_paused : cts_in;
        send_ctrl   = inband & pend_v & ~ser_busy;
        send_pay    = ~ser_busy & ~send_ctrl & pay_valid & pay_allowed;
    end

    // Pending slot: a new event overwrites, a load empties it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_v <= 1'b0;
            pend_c <= '0;
        end else if (inband && stop_rise) begin
            pend_v <= 1'b1;
            pend_c <= FC_CHAR_PAUSE;
        end else if (inband && stop_fall) begin
            pend_v <= 1'b1;
            pend_c <= FC_CHAR_RESUME;
        end else if (send_ctrl) begin
            pend_v <= 1'b0;
        end
    end

    assign pay_ready = send_pay;
    assign ser_load  = send_ctrl | send_pay;
    assign ser_byte  = send_ctrl ? pend_c : pay_byte;
endmodule

// File: rtl/uart_flow_ctrl.sv
// Serial link flow controller top level.
// Joins the fill-level tracker, the receive filter and the transmit arbiter.
// mode_sel is expected to change only while reset is asserted.
module uart_flow_ctrl
    import fc_pkg::*;
#(
    parameter int OCC_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_sel,
    input  logic [OCC_W-1:0] occupancy,
    input  logic [OCC_W-1:0] thresh_hi,
    input  logic [OCC_W-1:0] thresh_lo,
    input  logic             rx_in_valid,
    input  logic [7:0]       rx_in_byte,
    output logic             rx_out_valid,
    output logic [7:0]       rx_out_byte,
    input  logic             pay_valid,
    input  logic [7:0]       pay_byte,
    output logic             pay_ready,
    input  logic             ser_busy,
    output logic             ser_load,
    output logic [7:0]       ser_byte,
    input  logic             cts_in,
    output logic             rts_out
);
    logic inband;
    logic stopped;
    logic stop_rise;
    logic stop_fall;
    logic remote_paused;

    assign inband = (fc_mode_e'(mode_sel) == FC_MODE_INBAND);

    fc_level_track #(.OCC_W(OCC_W)) u_level (
        .clk       (clk),
        .rst_n     (rst_n),
        .occ       (occupancy),
        .hi        (thresh_hi),
        .lo        (thresh_lo),
        .stopped   (stopped),
        .stop_rise (stop_rise),
        .stop_fall (stop_fall)
    );

    fc_rx_filter u_rxf (
        .clk           (clk),
        .rst_n         (rst_n),
        .inband        (inband),
        .in_valid      (rx_in_valid),
        .in_byte       (rx_in_byte),
        .out_valid     (rx_out_valid),
        .out_byte      (rx_out_byte),
        .remote_paused (remote_paused)
    );

    fc_tx_arbiter u_txa (
        .clk           (clk),
        .rst_n         (rst_n),
        .inband        (inband),
        .stop_rise     (stop_rise),
        .stop_fall     (stop_fall),
        .cts_in        (cts_in),
        .remote_paused (remote_paused),
        .ser_busy      (ser_busy),
        .pay_valid     (pay_valid),
        .pay_byte      (pay_byte),
        .pay_ready     (pay_ready),
        .ser_load      (ser_load),
        .ser_byte      (ser_byte)
    );

    // Ready-to-receive drops only in wire mode while stopped.
    assign rts_out = ~(~inband & stopped);
endmodule

// File: rtl/fc_checker.sv
// Property checker for uart_flow_ctrl, attached by bind. Observes ports only.
module fc_checker #(
    parameter int OCC_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mode_sel,
    input logic [OCC_W-1:0] occupancy,
    input logic [OCC_W-1:0] thresh_hi,
    input logic [OCC_W-1:0] thresh_lo,
    input logic             rx_in_valid,
    input logic [7:0]       rx_in_byte,
    input logic             rx_out_valid,
    input logic             pay_valid,
    input logic             pay_ready,
    input logic             ser_busy,
    input logic             ser_load,
    input logic             cts_in,
    input logic             rts_out
);
    assert_wire_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_sel && ser_load) |-> (cts_in && pay_valid && pay_ready));

    assert_hold_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ser_busy |-> !ser_load);

    assert_high_stop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_sel && occupancy >= thresh_hi) |=> (mode_sel || !rts_out));

    assert_band_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_sel && !rts_out && occupancy >= thresh_lo) |=> (mode_sel || !rts_out));

    assert_inband_rts_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mode_sel |-> rts_out);

    assert_pause_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel && rx_in_valid && rx_in_byte == 8'h13) |=> (!mode_sel || !pay_ready));

    assert_swallow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel && rx_in_valid && (rx_in_byte == 8'h13 || rx_in_byte == 8'h11))
            |-> !rx_out_valid);
endmodule

bind uart_flow_ctrl fc_checker #(.OCC_W(OCC_W)) u_fc_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode_sel     (mode_sel),
    .occupancy    (occupancy),
    .thresh_hi    (thresh_hi),
    .thresh_lo    (thresh_lo),
    .rx_in_valid  (rx_in_valid),
    .rx_in_byte   (rx_in_byte),
    .rx_out_valid (rx_out_valid),
    .pay_valid    (pay_valid),
    .pay_ready    (pay_ready),
    .ser_busy     (ser_busy),
    .ser_load     (ser_load),
    .cts_in       (cts_in),
    .rts_out      (rts_out)
);

// File: tb/tb_uart_flow_ctrl.sv
// Bench for uart_flow_ctrl: behavioural reference model checked every clock,
// plus directed checks for the corner cases.
module tb_uart_flow_ctrl;
    localparam int OCC_W = 6;
    localparam int FRAME = 6;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             mode_sel;
    logic [OCC_W-1:0] occupancy, thresh_hi, thresh_lo;
    logic             rx_in_valid;
    logic [7:0]       rx_in_byte;
    logic             rx_out_valid;
    logic [7:0]       rx_out_byte;
    logic             pay_valid;
    logic [7:0]       pay_byte;
    logic             pay_ready;
    logic             ser_busy;
    logic             ser_load;
    logic [7:0]       ser_byte;
    logic             cts_in;
    logic             rts_out;

    always #10 clk = ~clk;

    uart_flow_ctrl #(.OCC_W(OCC_W)) dut (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .occupancy(occupancy),
        .thresh_hi(thresh_hi), .thresh_lo(thresh_lo), .rx_in_valid(rx_in_valid),
        .rx_in_byte(rx_in_byte), .rx_out_valid(rx_out_valid), .rx_out_byte(rx_out_byte),
        .pay_valid(pay_valid), .pay_byte(pay_byte), .pay_ready(pay_ready),
        .ser_busy(ser_busy), .ser_load(ser_load), .ser_byte(ser_byte),
        .cts_in(cts_in), .rts_out(rts_out)
    );

    int n_checks = 0;
    int n_fail   = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Serializer and payload source models.
    int busy_cnt;
    assign ser_busy = (busy_cnt != 0);
    always @(posedge clk) begin
        if (!rst_n)             busy_cnt <= 0;
        else if (ser_load)      busy_cnt <= FRAME;
        else if (busy_cnt != 0) busy_cnt <= busy_cnt - 1;
    end
    always @(posedge clk) begin
        if (!rst_n)         pay_byte <= 8'h40;
        else if (pay_ready) pay_byte <= pay_byte + 8'd1;
    end

    // Reference model state.
    bit m_stop, m_paused, m_pv;
    bit n_stop, n_paused, n_pv;
    logic [7:0] m_pc, n_pc;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_stop <= 0; m_paused <= 0; m_pv <= 0; m_pc <= 8'h00;
        end else begin
            m_stop <= n_stop; m_paused <= n_paused; m_pv <= n_pv; m_pc <= n_pc;
        end
    end

    // Per-cycle comparison and next-state computation.
    always @(negedge clk) begin
        bit hw, e_rts, e_ctrl, e_pay, e_load, e_rxv, flowc;
        logic [7:0] e_byte;
        if (rst_n) begin
            hw     = (mode_sel == 1'b0);
            e_rts  = !(hw && m_stop);
            e_ctrl = !hw && m_pv && !ser_busy;
            e_pay  = !ser_busy && !e_ctrl && pay_valid && (hw ? cts_in : !m_paused);
            e_load = e_ctrl || e_pay;
            e_byte = e_ctrl ? m_pc : pay_byte;
            flowc  = (rx_in_byte == 8'h11) || (rx_in_byte == 8'h13);
            e_rxv  = rx_in_valid && !(!hw && flowc);
            check(rts_out == e_rts, "R4/R5/R6 rts_out", rts_out, e_rts);
            check(ser_load == e_load, "R2/R3/R7/R9 ser_load", ser_load, e_load);
            check(pay_ready == e_pay, "R2/R9 pay_ready", pay_ready, e_pay);
            if (e_load) check(ser_byte == e_byte, "R6/R7/R8 ser_byte", ser_byte, e_byte);
            check(rx_out_valid == e_rxv, "R10 rx_out_valid", rx_out_valid, e_rxv);
            if (e_rxv) check(rx_out_byte == rx_in_byte, "R10 rx_out_byte", rx_out_byte, rx_in_byte);
            n_stop = m_stop ? (occupancy >= thresh_lo) : (occupancy >= thresh_hi);
            n_pv = m_pv; n_pc = m_pc;
            if (!hw && !m_stop && n_stop)      begin n_pv = 1; n_pc = 8'h13; end
            else if (!hw && m_stop && !n_stop) begin n_pv = 1; n_pc = 8'h11; end
            else if (e_ctrl)                   n_pv = 0;
            n_paused = m_paused;
            if (!hw && rx_in_valid && rx_in_byte == 8'h13)      n_paused = 1;
            else if (!hw && rx_in_valid && rx_in_byte == 8'h11) n_paused = 0;
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic wait_load(output logic [7:0] b);
        b = 8'h00;
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            if (ser_load) begin b = ser_byte; break; end
        end
        step(1);
    endtask

    task automatic do_reset(input logic m);
        rst_n = 0; mode_sel = m; occupancy = 0; rx_in_valid = 0; pay_valid = 0; cts_in = 1;
        step(3);
        rst_n = 1;
        step(1);
    endtask

    task automatic random_phase(input int cycles);
        for (int i = 0; i < cycles; i++) begin
            if (i % 7 == 0) occupancy = OCC_W'($urandom_range(0, 63));
            cts_in      = ($urandom % 4) != 0;
            pay_valid   = ($urandom % 5) != 0;
            rx_in_valid = ($urandom % 3) == 0;
            case ($urandom % 4)
                0:       rx_in_byte = 8'h13;
                1:       rx_in_byte = 8'h11;
                default: rx_in_byte = 8'($urandom);
            endcase
            step(1);
        end
        rx_in_valid = 0;
    endtask

    initial begin
        logic [7:0] b;
        int cnt;
        thresh_hi = 6'd40; thresh_lo = 6'd20; rx_in_byte = 8'h00;
        do_reset(1'b0);
        @(negedge clk);
        check(rts_out == 1'b1, "R1 rts_out after reset", rts_out, 1);
        check(ser_load == 1'b0, "R1 no load after reset", ser_load, 0);
        step(1);

        // Wire mode: stream, CTS drop, thresholds.
        pay_valid = 1; step(9);
        cts_in = 0; step(15);
        cts_in = 1; step(6);
        occupancy = 6'd44; step(1);
        @(negedge clk); check(rts_out == 1'b0, "R4 stop at high", rts_out, 0);
        occupancy = 6'd30; step(3);
        @(negedge clk); check(rts_out == 1'b0, "R5 hold between thresholds", rts_out, 0);
        occupancy = 6'd20; step(2);
        @(negedge clk); check(rts_out == 1'b0, "R5 hold at low", rts_out, 0);
        occupancy = 6'd10; step(1);
        @(negedge clk); check(rts_out == 1'b1, "R5 release below low", rts_out, 1);
        rx_in_valid = 1; rx_in_byte = 8'h13;
        @(negedge clk); check(rx_out_valid == 1'b1, "R10 wire mode forwards 0x13", rx_out_valid, 1);
        step(1); rx_in_valid = 0; step(20);

        // In-band mode.
        do_reset(1'b1);
        pay_valid = 1; step(4);
        occupancy = 6'd50; step(1);
        wait_load(b);
        check(b == 8'h13, "R6 pause char queued", b, 8'h13);
        @(negedge clk); check(rts_out == 1'b1, "R6 rts high in-band", rts_out, 1);
        wait_load(b);
        occupancy = 6'd5; step(1);
        occupancy = 6'd50; step(1);
        occupancy = 6'd30;
        wait_load(b);
        check(b == 8'h13, "R8 newer event replaces pending", b, 8'h13);
        occupancy = 6'd10; step(1);
        rx_in_valid = 1; rx_in_byte = 8'h13;
        @(negedge clk); check(rx_out_valid == 1'b0, "R10 pause char swallowed", rx_out_valid, 0);
        step(1); rx_in_byte = 8'h55;
        @(negedge clk); check(rx_out_valid && rx_out_byte == 8'h55, "R10 data forwarded", rx_out_byte, 8'h55);
        step(1); rx_in_valid = 0;
        cnt = 0;
        for (int i = 0; i < 20; i++) begin @(negedge clk); if (pay_ready) cnt++; end
        check(cnt == 0, "R9 payload held while paused", cnt, 0);
        step(1);
        rx_in_valid = 1; rx_in_byte = 8'h11; step(1); rx_in_valid = 0;
        cnt = 0;
        for (int i = 0; i < 20; i++) begin @(negedge clk); if (pay_ready) cnt++; end
        check(cnt > 0, "R9 payload resumes", cnt, 1);
        step(1);
        random_phase(500);

        do_reset(1'b0);
        random_phase(400);
        step(3);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(20 * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule